// File: doc/BRIEF.md
# DMA Channel Request Arbiter

This block sits in front of a DMA transfer engine and decides which of eight channels the engine serves next. Each channel picks its hardware trigger from seven trigger lines using a 3-bit source code. Code 0 means the channel has no hardware trigger. Every trigger line comes as a pair: a single-request wire and a burst-request wire. Each channel also carries four attribute bits, an enable bit and a latched software request. A register-style write port changes this state and a combinational read port shows it.

When no grant is held and the module enable is high, the arbiter takes the pending channels and grants one of them. It presents the channel number together with the channel's alternate-structure and burst attributes. The grant stays in place until the engine reports either the end of an arbitration block or the end of the whole transfer. The end of a transfer also clears that channel's enable, so software must enable the channel again before its next transfer.

Top module: `dma_req_arbiter`

## Requirements
- R1: After reset no grant is held, and every channel reads back with its enable, attributes and source code all zero.
- R2: A channel's hardware request follows the trigger pair picked by its source code, and code 0 never requests. With attribute bit 0 (burst-only) clear, either wire of the pair requests. With bit 0 set, only the burst wire requests.
- R3: With attribute bit 3 (hardware mask) set, a channel ignores its trigger, but a software request on it is still granted.
- R4: A channel whose enable is clear is never granted, and a software request written to it while disabled is dropped (not latched).
- R5: While `mod_en` is low no new grant is issued; requests stay pending and are granted once `mod_en` returns high.
- R6: Channels with attribute bit 2 (high priority) set win over all others. Within the same class, the lowest channel number wins.
- R7: A grant appears on the clock edge that samples a pending channel while idle. It is held with a stable channel number until `eng_blk_done` or `eng_xfer_done` is sampled high. `gnt_valid` is then low for one cycle before the next grant. `eng_blk_done` alone leaves the enable set.
- R8: `eng_xfer_done` during a grant clears the granted channel's enable and its software request.
- R9: A software request stays latched until the channel is granted or disabled.
- R10: Attribute writes set or clear bits by mask, and `rd_attr` returns the 4-bit mask. `gnt_alt` and `gnt_burst` show bit 1 and bit 0 of the granted channel.
- R11: Write op codes are 1 enable, 2 disable, 3 attribute set, 4 attribute clear, 5 source set (`wr_data[2:0]`) and 6 software request. Codes 0 and 7 change nothing. A register write takes effect after any engine update in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mod_en | input | 1 | Global enable for issuing grants |
| trig_single | input | 7 | Single-request wires of trigger sources 1..7 |
| trig_burst | input | 7 | Burst-request wires of trigger sources 1..7 |
| wr_valid | input | 1 | Register write strobe |
| wr_op | input | 3 | Write operation code |
| wr_chan | input | 3 | Channel addressed by the write |
| wr_data | input | 4 | Attribute mask or source code |
| rd_chan | input | 3 | Channel shown on the read port |
| rd_en | output | 1 | Enable bit of `rd_chan` |
| rd_attr | output | 4 | Attribute bits of `rd_chan` |
| rd_src | output | 3 | Source code of `rd_chan` |
| eng_blk_done | input | 1 | Engine finished an arbitration block |
| eng_xfer_done | input | 1 | Engine finished the whole transfer |
| gnt_valid | output | 1 | A channel is granted |
| gnt_chan | output | 3 | Granted channel number |
| gnt_alt | output | 1 | Alternate-structure attribute of granted channel |
| gnt_burst | output | 1 | Burst-only attribute of granted channel |

## Verification
The assertions assume that the engine strobes mean something only while a grant is held. The design ignores them otherwise, and the random stimulus raises them at any time to confirm this. The check that the enable clears after a transfer leaves out the case where an enable write to the granted channel lands in the same cycle, because the write order gives that write precedence. The stimulus produces that collision freely. Triggers are made sparse by ANDing several random words, the module enable is kept mostly high, and enable writes are frequent enough that grants keep occurring. Directed steps cover masking, burst-only qualification, priority order and the one-cycle gap after a release.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
    localparam int ATTR_W   = 4;
    localparam int AT_BURST = 0;
    localparam int AT_ALT   = 1;
    localparam int AT_HIPRI = 2;
    localparam int AT_MASK  = 3;

    typedef enum logic [2:0] {
        OP_NOP      = 3'd0,
        OP_CH_ON    = 3'd1,
        OP_CH_OFF   = 3'd2,
        OP_ATTR_SET = 3'd3,
        OP_ATTR_CLR = 3'd4,
        OP_SRC_SET  = 3'd5,
        OP_SW_REQ   = 3'd6
    } reg_op_e;
endpackage

// File: rtl/dma_arb_reqgen.sv
module dma_arb_reqgen #(
    parameter int NUM_CH = 8,
    parameter int SRC_W  = 3
) (
    input  logic [(1<<SRC_W)-1:1]    trig_single,
    input  logic [(1<<SRC_W)-1:1]    trig_burst,
    input  logic [NUM_CH*SRC_W-1:0]  src_flat,
    input  logic [NUM_CH-1:0]        burst_only,
    input  logic [NUM_CH-1:0]        hw_mask,
    output logic [NUM_CH-1:0]        hw_req
);
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic [SRC_W-1:0] sel;
        logic             line;
        assign sel  = src_flat[c*SRC_W +: SRC_W];
        always_comb begin
            line = 1'b0;
            if (sel != '0) begin
                line = burst_only[c] ? trig_burst[sel]
                                     : (trig_burst[sel] | trig_single[sel]);
            end
        end
        assign hw_req[c] = line & ~hw_mask[c];
    end
endmodule

// File: rtl/dma_arb_pick.sv
module dma_arb_pick #(
    parameter int NUM_CH = 8,
    localparam int CH_W  = $clog2(NUM_CH)
) (
    input  logic [NUM_CH-1:0] pend,
    input  logic [NUM_CH-1:0] hipri,
    output logic              any,
    output logic [CH_W-1:0]   win
);
    logic [NUM_CH-1:0] hi_set;
    logic [NUM_CH-1:0] cand;

    always_comb begin
        hi_set = pend & hipri;
        cand   = (|hi_set) ? hi_set : pend;
        any    = |pend;
        win    = '0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (cand[i]) win = CH_W'(i);
        end
    end
endmodule

// File: rtl/dma_req_arbiter.sv
module dma_req_arbiter
    import dma_arb_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int SRC_W  = 3,
    localparam int CH_W  = $clog2(NUM_CH),
    localparam int WD_W  = (SRC_W > ATTR_W) ? SRC_W : ATTR_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  mod_en,
    input  logic [(1<<SRC_W)-1:1] trig_single,
    input  logic [(1<<SRC_W)-1:1] trig_burst,
    input  logic                  wr_valid,
    input  logic [2:0]            wr_op,
    input  logic [CH_W-1:0]       wr_chan,
    input  logic [WD_W-1:0]       wr_data,
    input  logic [CH_W-1:0]       rd_chan,
    output logic                  rd_en,
    output logic [ATTR_W-1:0]     rd_attr,
    output logic [SRC_W-1:0]      rd_src,
    input  logic                  eng_blk_done,
    input  logic                  eng_xfer_done,
    output logic                  gnt_valid,
    output logic [CH_W-1:0]       gnt_chan,
    output logic                  gnt_alt,
    output logic                  gnt_burst
);
    typedef struct packed {
        logic [NUM_CH-1:0]             en;
        logic [NUM_CH-1:0][ATTR_W-1:0] attr;
        logic [NUM_CH-1:0][SRC_W-1:0]  src;
        logic [NUM_CH-1:0]             swp;
        logic                          gnt;
        logic [CH_W-1:0]               gch;
    } arb_state_t;

    arb_state_t s_d, s_q;

    logic [NUM_CH-1:0]       burst_v, mask_v, hipri_v, hw_req, pend;
    logic [NUM_CH*SRC_W-1:0] src_flat;
    logic                    any_pend;
    logic [CH_W-1:0]         winner;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_attr
        assign burst_v[c] = s_q.attr[c][AT_BURST];
        assign mask_v[c]  = s_q.attr[c][AT_MASK];
        assign hipri_v[c] = s_q.attr[c][AT_HIPRI];
    end
    assign src_flat = s_q.src;

    dma_arb_reqgen #(.NUM_CH(NUM_CH), .SRC_W(SRC_W)) u_reqgen (
        .trig_single (trig_single),
        .trig_burst  (trig_burst),
        .src_flat    (src_flat),
        .burst_only  (burst_v),
        .hw_mask     (mask_v),
        .hw_req      (hw_req)
    );

    assign pend = s_q.en & (hw_req | s_q.swp);

    dma_arb_pick #(.NUM_CH(NUM_CH)) u_pick (
        .pend  (pend),
        .hipri (hipri_v),
        .any   (any_pend),
        .win   (winner)
    );

    always_comb begin
        s_d = s_q;
        // engine side first
        if (s_q.gnt && (eng_blk_done || eng_xfer_done)) begin
            s_d.gnt = 1'b0;
            if (eng_xfer_done) begin
                s_d.en[s_q.gch]  = 1'b0;
                s_d.swp[s_q.gch] = 1'b0;
            end
        end else if (!s_q.gnt && mod_en && any_pend) begin
            s_d.gnt         = 1'b1;
            s_d.gch         = winner;
            s_d.swp[winner] = 1'b0;
        end
        // register writes take precedence
        if (wr_valid) begin
            case (reg_op_e'(wr_op))
                OP_CH_ON:    s_d.en[wr_chan] = 1'b1;
                OP_CH_OFF: begin
                    s_d.en[wr_chan]  = 1'b0;
                    s_d.swp[wr_chan] = 1'b0;
                end
                OP_ATTR_SET: s_d.attr[wr_chan] = s_q.attr[wr_chan] | wr_data[ATTR_W-1:0];
                OP_ATTR_CLR: s_d.attr[wr_chan] = s_d.attr[wr_chan] & ~wr_data[ATTR_W-1:0];
                OP_SRC_SET:  s_d.src[wr_chan]  = wr_data[SRC_W-1:0];
                OP_SW_REQ:   if (s_q.en[wr_chan]) s_d.swp[wr_chan] = 1'b1;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rd_en     = s_q.en[rd_chan];
    assign rd_attr   = s_q.attr[rd_chan];
    assign rd_src    = s_q.src[rd_chan];
    assign gnt_valid = s_q.gnt;
    assign gnt_chan  = s_q.gch;
    assign gnt_alt   = s_q.attr[s_q.gch][AT_ALT];
    assign gnt_burst = s_q.attr[s_q.gch][AT_BURST];

    // a fresh grant goes only to a channel that was enabled and pending (R4)
    assert_grant_was_pending_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.gnt) |-> |($past(pend) & (NUM_CH'(1) << s_q.gch)));

    // no fresh grant while the module enable was low (R5)
    assert_no_grant_when_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.gnt) |-> $past(mod_en));

    // high-priority pending channel always beats a normal one (R6)
    assert_hipri_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(s_q.gnt) && $past(|(pend & hipri_v)))
        |-> |($past(hipri_v) & (NUM_CH'(1) << s_q.gch)));

    // grant held steady until the engine releases it (R7)
    assert_grant_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.gnt && !eng_blk_done && !eng_xfer_done) |=> (s_q.gnt && $stable(s_q.gch)));

    // release is followed by an idle cycle (R7)
    assert_idle_after_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.gnt && (eng_blk_done || eng_xfer_done)) |=> !s_q.gnt);

    // transfer completion drops the enable unless re-enabled in that cycle (R8)
    assert_done_clears_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.gnt && eng_xfer_done &&
         !(wr_valid && wr_op == OP_CH_ON && wr_chan == s_q.gch))
        |=> !s_q.en[$past(s_q.gch)]);
endmodule

// File: tb/dma_req_arbiter_test.sv
`timescale 1ns/1ps
module dma_req_arbiter_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mod_en = 1'b0;
    logic [7:1] ts = '0, tbr = '0;
    logic       wr_valid = 1'b0;
    logic [2:0] wr_op = '0, wr_chan = '0, rdc = '0;
    logic [3:0] wr_data = '0;
    logic       bd = 1'b0, xd = 1'b0;
    logic       rd_en, gnt_valid, gnt_alt, gnt_burst;
    logic [3:0] rd_attr;
    logic [2:0] rd_src, gnt_chan;

    int n_chk = 0, n_err = 0;
    bit finished = 0;

    // bench reference state
    bit [7:0] m_en = '0, m_swp = '0;
    bit [3:0] m_attr [8];
    bit [2:0] m_src [8];
    bit       m_gnt = 0;
    int       m_gch = 0;

    always #4 clk = ~clk;

    dma_req_arbiter uut (
        .clk(clk), .rst_n(rst_n), .mod_en(mod_en),
        .trig_single(ts), .trig_burst(tbr),
        .wr_valid(wr_valid), .wr_op(wr_op), .wr_chan(wr_chan), .wr_data(wr_data),
        .rd_chan(rdc), .rd_en(rd_en), .rd_attr(rd_attr), .rd_src(rd_src),
        .eng_blk_done(bd), .eng_xfer_done(xd),
        .gnt_valid(gnt_valid), .gnt_chan(gnt_chan),
        .gnt_alt(gnt_alt), .gnt_burst(gnt_burst)
    );

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int pick(bit [7:0] p);
        bit [7:0] hi = '0;
        for (int c = 0; c < 8; c++) hi[c] = p[c] & m_attr[c][2];
        if (hi != 0) p = hi;
        for (int c = 0; c < 8; c++) if (p[c]) return c;
        return 0;
    endfunction

    function automatic bit hw_line(int c);
        int s = m_src[c];
        if (s == 0 || m_attr[c][3]) return 0;
        return m_attr[c][0] ? tbr[s] : (tbr[s] | ts[s]);
    endfunction

    task automatic model_update();
        bit [7:0] pend = '0;
        bit [7:0] n_en = m_en, n_swp = m_swp;
        bit [3:0] n_attr [8];
        bit [2:0] n_src [8];
        bit n_gnt = m_gnt;
        int n_gch = m_gch;
        for (int c = 0; c < 8; c++) begin
            pend[c] = m_en[c] & (hw_line(c) | m_swp[c]);
            n_attr[c] = m_attr[c];
            n_src[c]  = m_src[c];
        end
        if (m_gnt && (bd || xd)) begin
            n_gnt = 0;
            if (xd) begin n_en[m_gch] = 0; n_swp[m_gch] = 0; end
        end else if (!m_gnt && mod_en && pend != 0) begin
            n_gnt = 1; n_gch = pick(pend); n_swp[n_gch] = 0;
        end
        if (wr_valid) begin
            case (wr_op)
                3'd1: n_en[wr_chan] = 1;
                3'd2: begin n_en[wr_chan] = 0; n_swp[wr_chan] = 0; end
                3'd3: n_attr[wr_chan] = n_attr[wr_chan] | wr_data;
                3'd4: n_attr[wr_chan] = n_attr[wr_chan] & ~wr_data;
                3'd5: n_src[wr_chan] = wr_data[2:0];
                3'd6: if (m_en[wr_chan]) n_swp[wr_chan] = 1;
                default: ;
            endcase
        end
        m_en = n_en; m_swp = n_swp; m_gnt = n_gnt; m_gch = n_gch;
        for (int c = 0; c < 8; c++) begin m_attr[c] = n_attr[c]; m_src[c] = n_src[c]; end
    endtask

    task automatic compare();
        chk("R7 grant valid", gnt_valid, m_gnt);
        if (m_gnt) begin
            chk("R6 grant channel", gnt_chan, m_gch);
            chk("R10 grant alt", gnt_alt, m_attr[m_gch][1]);
            chk("R10 grant burst", gnt_burst, m_attr[m_gch][0]);
        end
        chk("R10 read enable", rd_en, m_en[rdc]);
        chk("R10 read attr", rd_attr, m_attr[rdc]);
        chk("R11 read source", rd_src, m_src[rdc]);
    endtask

    task automatic tick();
        @(posedge clk);
        model_update();
        @(negedge clk);
        compare();
    endtask

    task automatic wr(int op, int ch, int data);
        wr_valid = 1; wr_op = 3'(op); wr_chan = 3'(ch); wr_data = 4'(data);
        tick();
        wr_valid = 0; wr_op = '0;
    endtask

    task automatic release_grant(bit full);
        if (full) xd = 1; else bd = 1;
        tick();
        xd = 0; bd = 0;
    endtask

    initial begin
        for (int c = 0; c < 8; c++) begin m_attr[c] = '0; m_src[c] = '0; end
        void'($urandom(32'h00C0FFEE));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        // R1: reset state on every channel
        chk("R1 grant after reset", gnt_valid, 0);
        for (int c = 0; c < 8; c++) begin
            rdc = 3'(c); #1;
            chk("R1 enable after reset", rd_en, 0);
            chk("R1 attr after reset", rd_attr, 0);
            chk("R1 source after reset", rd_src, 0);
        end
        mod_en = 1;

        // R2: trigger selection, either wire
        wr(5, 2, 5); wr(1, 2, 0);
        ts[5] = 1; tick();
        chk("R2 grant on selected single wire", gnt_valid, 1);
        chk("R2 granted channel", gnt_chan, 2);
        ts = '0;
        release_grant(0);
        chk("R7 released after block end", gnt_valid, 0);

        // R2: burst-only ignores the single wire
        wr(3, 2, 1);
        ts[5] = 1; tick(); tick();
        chk("R2 burst-only ignores single", gnt_valid, 0);
        tbr[5] = 1; tick();
        chk("R2 burst wire grants", gnt_valid, 1);
        chk("R10 burst attribute shown", gnt_burst, 1);
        ts = '0; tbr = '0;
        release_grant(1);
        rdc = 2; #1;
        chk("R8 enable cleared by transfer end", rd_en, 0);
        wr(4, 2, 1);

        // R3: mask blocks hardware, not software
        wr(5, 4, 3); wr(1, 4, 0); wr(3, 4, 8);
        ts[3] = 1; tick(); tick();
        chk("R3 masked trigger ignored", gnt_valid, 0);
        wr(6, 4, 0); tick();
        chk("R3 software request on masked channel", gnt_valid, 1);
        chk("R3 granted channel", gnt_chan, 4);
        ts = '0;
        release_grant(1);
        wr(4, 4, 8);

        // R4: disabled channel ignores everything
        wr(5, 1, 1);
        ts[1] = 1; tick();
        chk("R4 disabled ignores trigger", gnt_valid, 0);
        wr(6, 1, 0);
        ts = '0;
        wr(1, 1, 0); tick();
        chk("R4 software request not latched", gnt_valid, 0);

        // R5: module enable gates grants
        mod_en = 0;
        wr(6, 1, 0); tick(); tick();
        chk("R5 no grant while module off", gnt_valid, 0);
        mod_en = 1; tick();
        chk("R5 grant after module on", gnt_valid, 1);
        chk("R5 granted channel", gnt_chan, 1);
        release_grant(0);
        chk("R7 idle after release", gnt_valid, 0);
        rdc = 1; #1;
        chk("R7 block end keeps enable", rd_en, 1);
        tick();
        chk("R9 software request consumed by grant", gnt_valid, 0);

        // R9: disable drops a latched request
        mod_en = 0;
        wr(6, 1, 0); wr(2, 1, 0); wr(1, 1, 0);
        mod_en = 1; tick(); tick();
        chk("R9 disable clears pending request", gnt_valid, 0);

        // R6: priority order
        mod_en = 0;
        wr(1, 3, 0); wr(1, 5, 0); wr(1, 6, 0);
        wr(6, 3, 0); wr(6, 5, 0); wr(6, 6, 0);
        wr(3, 6, 4);
        mod_en = 1; tick();
        chk("R6 high priority first", gnt_chan, 6);
        release_grant(0); tick();
        chk("R6 lowest number next", gnt_chan, 3);
        release_grant(0); tick();
        chk("R6 remaining channel", gnt_chan, 5);
        release_grant(0);

        // R10: attribute set/clear and grant sidebands
        wr(3, 7, 15); wr(4, 7, 5);
        rdc = 7; #1;
        chk("R10 attribute mask readback", rd_attr, 10);
        wr(1, 7, 0); wr(6, 7, 0); tick();
        chk("R10 granted channel", gnt_chan, 7);
        chk("R10 alternate bit shown", gnt_alt, 1);
        chk("R10 burst bit shown", gnt_burst, 0);
        release_grant(1);
        wr(4, 7, 15);

        // R11: unused op code changes nothing
        wr(5, 0, 6); wr(7, 0, 3);
        rdc = 0; #1;
        chk("R11 source set", rd_src, 6);
        chk("R11 unused op leaves attr", rd_attr, 0);
        chk("R11 unused op leaves enable", rd_en, 0);

        // constrained random phase
        for (int i = 0; i < 4000; i++) begin
            ts       = 7'($urandom & $urandom & $urandom);
            tbr      = 7'($urandom & $urandom & $urandom & $urandom);
            wr_valid = ($urandom % 2) == 0;
            wr_op    = 3'($urandom % 8);
            if (($urandom % 4) == 0) wr_op = 3'd1;
            wr_chan  = 3'($urandom % 8);
            wr_data  = 4'($urandom % 16);
            bd       = ($urandom % 6) == 0;
            xd       = ($urandom % 10) == 0;
            mod_en   = ($urandom % 16) != 0;
            rdc      = 3'($urandom % 8);
            tick();
        end
        wr_valid = 0; bd = 0; xd = 0;

        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        #(200000 * 8);
        if (!finished) begin
            finished = 1;
            n_chk++; n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end
endmodule